// File: doc/BRIEF.md
# Transmit Frame Byte Streamer

This block holds one outgoing frame in a byte-wide buffer RAM and plays it out to a MAC as a byte-wide AXI4-Stream master. Software fills the buffer through a simple write port, presents a byte count on `frame_len`, and pulses `send`. The streamer then hands over exactly that many bytes, starting at buffer address 0, marks the last one with `m_tlast`, raises `done` for one cycle, and goes back to idle. Preamble, FCS, inter-frame gap and the PHY side are left to the MAC.

The frame ends when the block's own beat counter reaches the latched length. It does not depend on any activity report from the MAC. Both the read-address counter and `m_tvalid` are qualified by an internal transmit-enable that is true only while a frame is being streamed. This means no stray valid beat can trail a frame, and no frame can run on past its length.

The control is a four-state machine: `ST_IDLE` waits for a send. `ST_LOAD` issues the first RAM read into a one-entry prefetch register. `ST_STREAM` presents bytes and refetches on each handshake. `ST_DONE` pulses `done` and clears the counters. The transitions are: IDLE→LOAD on a send with a non-zero length, LOAD→STREAM always, STREAM→DONE on the handshake of the final byte, and DONE→IDLE always.

Top module: `txf_streamer`

## Requirements
- R1: After reset, `m_tvalid`, `m_tlast`, `busy` and `done` are all low.
- R2: A `send` pulse in idle with `frame_len` = N (1 ≤ N ≤ DEPTH) produces exactly N handshakes (`m_tvalid && m_tready`). Handshake k carries buffer byte k, for k = 0..N-1.
- R3: While `m_tvalid` is high, `m_tlast` is high if and only if the byte on offer is number N-1 of the frame.
- R4: While `m_tvalid` is high and `m_tready` is low, the next cycle still has `m_tvalid` high with `m_tdata` and `m_tlast` unchanged.
- R5: `m_tvalid` is low whenever no frame is being streamed. In particular it is low in every cycle after the final handshake until another accepted send.
- R6: `done` is high for exactly one cycle, namely the cycle after the final handshake. `busy` is high from the cycle after an accepted send through the `done` cycle, and low otherwise.
- R7: A `send` pulse or a change of `frame_len` while `busy` is high is ignored. The current frame keeps its length, and no further frame follows it.
- R8: A `send` with `frame_len` = 0 is a no-operation. `busy` stays low and no beat is offered.
- R9: Every frame reads the buffer from address 0, because the read-address counter holds at zero whenever the block is not busy. Back-to-back frames of different lengths (including 1, 64, 100, 1500 and DEPTH) each stream correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_waddr | input | AW | Buffer write address |
| buf_wdata | input | 8 | Buffer write byte |
| frame_len | input | LW | Frame length in bytes, sampled on an accepted send |
| send | input | 1 | Start pulse, acted on only in idle |
| m_tdata | output | 8 | Stream byte |
| m_tvalid | output | 1 | Stream valid |
| m_tlast | output | 1 | Final byte of the frame |
| m_tready | input | 1 | Stream ready from the MAC |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two events can share a cycle: a `send` pulse with a new length arriving while a frame is streaming, and the streamer's own length-driven end of frame. The bench provokes this by raising `send` with a different `frame_len` in the middle of a frame. It then checks that exactly the original number of bytes arrive, that `done` fires once, and that the line stays quiet afterwards. A second overlap is back-pressure falling on the beat that carries `m_tlast`. That case is provoked with a periodic `m_tready` gap pattern and judged by checking that data and last stay held and that `done` follows only the real handshake.

// File: rtl/txf_pkg.sv
package txf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_STREAM = 2'd2,
        ST_DONE   = 2'd3
    } txf_state_e;
endpackage

// File: rtl/txf_ram.sv
module txf_ram #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // read register doubles as the one-entry prefetch holding stage
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/txf_cnt.sv
module txf_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (inc)      q <= q + 1'b1;
    end
endmodule

// File: rtl/txf_streamer.sv
module txf_streamer
    import txf_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_waddr,
    input  logic [7:0]    buf_wdata,
    input  logic [LW-1:0] frame_len,
    input  logic          send,
    output logic [7:0]    m_tdata,
    output logic          m_tvalid,
    output logic          m_tlast,
    input  logic          m_tready,
    output logic          busy,
    output logic          done
);
    txf_state_e    state_q, state_d;
    logic [LW-1:0] len_q;
    logic [LW-1:0] addr_q;
    logic [LW-1:0] beat_q;
    logic          tx_en;
    logic          hs;
    logic          is_last;
    logic          accept;
    logic          cnt_clr;
    logic          rd_en;

    assign accept  = (state_q == ST_IDLE) && send && (frame_len != '0);
    assign tx_en   = (state_q == ST_STREAM);
    assign hs      = tx_en && m_tready;
    assign is_last = (beat_q == len_q - 1'b1);
    assign cnt_clr = (state_q == ST_DONE);
    assign rd_en   = (state_q == ST_LOAD) || hs;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      len_q <= '0;
        else if (accept) len_q <= frame_len;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_STREAM;
            ST_STREAM: if (hs && is_last) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        m_tvalid = tx_en;
        m_tlast  = tx_en && is_last;
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
    end

    // read-address counter: advances on the first fetch and on handshakes only
    txf_cnt #(.W(LW)) i_addr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (rd_en),
        .q     (addr_q)
    );

    // beat counter: decides the end of the frame
    txf_cnt #(.W(LW)) i_beat_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (hs),
        .q     (beat_q)
    );

    txf_ram #(.DEPTH(DEPTH), .AW(AW)) i_ram (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .re    (rd_en),
        .raddr (addr_q[AW-1:0]),
        .rdata (m_tdata)
    );
endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
    parameter int LW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    m_tdata,
    input logic          m_tvalid,
    input logic          m_tlast,
    input logic          m_tready,
    input logic          busy,
    input logic          done,
    input logic [LW-1:0] rd_addr
);
    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_tvalid); // R5

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tlast) |=> (done && !m_tvalid)); // R6

    AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid); // R3

    AST_ADDR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_addr == '0)); // R9
endmodule

bind txf_streamer txf_checker #(.LW(LW)) i_txf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tlast  (m_tlast),
    .m_tready (m_tready),
    .busy     (busy),
    .done     (done),
    .rd_addr  (addr_q)
);

// File: tb/test_txf_streamer.sv
`timescale 1ns/1ps
module test_txf_streamer;
    localparam int DEPTH = 2048;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          buf_we = 1'b0;
    logic [AW-1:0] buf_waddr = '0;
    logic [7:0]    buf_wdata = '0;
    logic [LW-1:0] frame_len = '0;
    logic          send = 1'b0;
    logic [7:0]    m_tdata;
    logic          m_tvalid;
    logic          m_tlast;
    logic          m_tready = 1'b1;
    logic          busy;
    logic          done;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    txf_streamer #(.DEPTH(DEPTH)) i_txf_streamer (
        .clk, .rst_n, .buf_we, .buf_waddr, .buf_wdata, .frame_len, .send,
        .m_tdata, .m_tvalid, .m_tlast, .m_tready, .busy, .done
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 13) + (seed * 29) + (i >> 8));
    endfunction

    task automatic fill(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            buf_we = 1'b1; buf_waddr = AW'(i); buf_wdata = pat(i, seed);
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    // stall > 0: ready is low one cycle out of every (stall+1)
    task automatic run_frame(input int len, input int seed, input int stall, input bit poke);
        int got = 0;
        int cyc = 0;
        bit held = 1'b0;
        logic [7:0] hd = '0;
        logic hl = 1'b0;
        @(negedge clk);
        frame_len = LW'(len); send = 1'b1;
        @(negedge clk);
        send = 1'b0;
        chk(busy == 1'b1, "R6 busy after send", int'(busy), 1);
        while (got < len && cyc < 20000) begin
            m_tready = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) != 0);
            if (poke && cyc == 10) begin send = 1'b1; frame_len = LW'(7); end
            else send = 1'b0;
            if (held) begin
                chk(m_tvalid && m_tdata == hd && m_tlast == hl, "R4 hold under stall",
                    int'(m_tdata), int'(hd));
            end
            held = m_tvalid && !m_tready;
            hd = m_tdata; hl = m_tlast;
            if (m_tvalid && m_tready) begin
                chk(m_tdata == pat(got, seed), "R2 byte value", int'(m_tdata), int'(pat(got, seed)));
                chk(m_tlast == (got == len - 1), "R3 last flag", int'(m_tlast), int'(got == len - 1));
                got++;
            end
            cyc++;
            @(negedge clk);
        end
        send = 1'b0;
        m_tready = 1'b1;
        chk(got == len, "R2 beat count", got, len);
        chk(done == 1'b1, "R6 done after last", int'(done), 1);
        chk(m_tvalid == 1'b0, "R5 no valid after last", int'(m_tvalid), 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R6 done single cycle", int'({done, busy}), 0);
        for (int k = 0; k < 12; k++) begin
            if (m_tvalid) chk(1'b0, poke ? "R7 no extra frame" : "R5 quiet after frame", 1, 0);
            @(negedge clk);
        end
        chk(m_tvalid == 1'b0 && busy == 1'b0, poke ? "R7 send ignored while busy" : "R5 idle line",
            int'(m_tvalid), 0);
    endtask

    task automatic t_reset();
        chk(!m_tvalid && !m_tlast && !busy && !done, "R1 reset state",
            int'({m_tvalid, m_tlast, busy, done}), 0);
    endtask

    task automatic t_zero_len();
        @(negedge clk);
        frame_len = '0; send = 1'b1;
        @(negedge clk);
        send = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (m_tvalid || busy) chk(1'b0, "R8 zero length activity", 1, 0);
            @(negedge clk);
        end
        chk(!m_tvalid && !busy, "R8 zero length no-op", int'({m_tvalid, busy}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        fill(64, 1);      run_frame(64, 1, 0, 1'b0);     // R2 R9 minimum Ethernet size
        fill(1500, 2);    run_frame(1500, 2, 2, 1'b0);   // R4 back-pressure on large frame
        fill(100, 3);     run_frame(100, 3, 0, 1'b0);    // R9 back-to-back differing sizes
        fill(64, 4);      run_frame(64, 4, 3, 1'b0);
        fill(1, 5);       run_frame(1, 5, 1, 1'b0);      // R3 single-byte frame
        t_zero_len();                                    // R8
        fill(200, 6);     run_frame(200, 6, 0, 1'b1);    // R7 send during stream
        fill(DEPTH, 7);   run_frame(DEPTH, 7, 4, 1'b0);  // R9 full buffer
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule